// File: doc/BRIEF.md
# Chip-Select Decode and Burst Sequencer

This block serves a single external memory bank. It holds one configuration word for the bank and compares the upper bits of every internal bus address against the bank's base address. When the bank is enabled and the address matches, it accepts the access and drives the external data phase. That phase consists of a chip select, one transfer acknowledge per data beat, a done flag on the final beat, a burst-in-progress strobe and four byte-lane strobes.

The number of beats depends on the transfer size in 32-bit words and on the port width. A burst read moves 4 or 8 words. It takes 4 or 8 beats on a 32-bit port and 8 or 16 beats on a 16-bit port. Writes, non-burst reads and reads to a bank with bursts inhibited use a single beat. Each beat is preceded by a wait-state count. The first beat uses its own count, and every later beat uses a second count. The burst-in-progress strobe is either held for the whole burst or raised only during the wait window of each later beat.

Configuration word layout (bit 0 = LSB): [31:15] base address (bits [31:29] fixed at 001), [14:12] later-beat wait count, [11] reserved, [10:8] first-beat wait count, [7:6] reserved, [5] strobe pulse mode, [4] byte-lane mode, [3] short burst, [2] narrow port, [1] burst inhibit, [0] bank enable.

Top module: `csel_burst_seq`

## Requirements
- R1: After reset, `cfg_rdata` is 32'h2000_0002: base bits [31:29] are 001, all other base bits are 0, burst inhibit is 1 and the bank enable is 0. `chip_sel` is 0 and `req_ready` is 1.
- R2: A write with `cfg_we` high updates the word at the next edge. The read-back equals the written data, except that bits [31:29] always read 001 and the reserved bits 11, 7 and 6 always read 0.
- R3: `hit` is 1 exactly when bit 0 is 1 and `req_addr[31:15]` equals `cfg_rdata[31:15]`. `chip_sel` never rises unless the enable bit and `hit` were both 1 at the accepting edge.
- R4: An access is accepted at an edge where `req_valid`, `hit` and `req_ready` are all 1. From the next cycle, `chip_sel` is 1 and `req_ready` is 0 until the cycle after `done`. No other request is taken in that time.
- R5: A read with `req_burst` set, when burst inhibit (bit 1) is 0, takes N beats. N is 4 when bit 3 is 1 and 8 when bit 3 is 0. N is doubled when the port is narrow, meaning bit 2 is 1 or `bus16` is 1. Every other access takes 1 beat. `ack` pulses once per beat, and `done` is 1 together with the last `ack` only.
- R6: The first `ack` comes in active cycle W1, where W1 is bits [10:8] and active cycles are counted from 0 at the first `chip_sel` cycle. Each later `ack` comes W2+1 cycles after the previous one, where W2 is bits [14:12].
- R7: With bit 5 = 0, `bdip` is 1 in every active cycle of a multi-beat access and 0 otherwise.
- R8: With bit 5 = 1, `bdip` is 1 only during the W2+1 cycles that lead up to each beat after the first. It is 0 during the first beat and for single-beat accesses.
- R9: With bit 4 = 0, `lane_stb` carries `req_be` for writes and is 0 for reads. With bit 4 = 1, it carries `req_be` for both reads and writes. The value is held through every active cycle, and `lane_stb` is 0 when `chip_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word write data |
| cfg_rdata | output | 32 | Configuration word read-back |
| bus16 | input | 1 | Global 16-bit data bus mode; forces a narrow port |
| req_valid | input | 1 | Internal bus access request |
| req_addr | input | 32 | Internal bus address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Master asks for a burst |
| req_be | input | 4 | Byte lanes of the access |
| req_ready | output | 1 | Sequencer idle, can accept an access |
| hit | output | 1 | Address decodes to this enabled bank |
| chip_sel | output | 1 | External chip select, active high |
| bdip | output | 1 | Burst data in progress strobe |
| lane_stb | output | 4 | Write-enable or byte-enable lane strobes |
| ack | output | 1 | Transfer acknowledge, one pulse per beat |
| done | output | 1 | Final beat of the access |

## Verification
`hit` is combinational and is due in the same cycle as the address. The configuration read-back and `chip_sel` are due one edge after the write or the acceptance. The bench therefore samples 1 ns after each falling edge, one cycle after the stimulus edge. During an access, the bench walks the active cycles itself. It tracks the expected beat index and the remaining wait count from W1 and W2, and compares `ack`, `done`, `bdip`, `lane_stb`, `chip_sel` and `req_ready` together in every cycle. It then checks that `chip_sel` drops and `req_ready` returns exactly one cycle after `done`.

// File: rtl/csb_pkg.sv
package csb_pkg;
  localparam int CFG_W     = 32;
  localparam int BASE_W    = 17;
  localparam int WAIT_W    = 3;
  localparam int BASE_LSB  = CFG_W - BASE_W;
  // control field positions
  localparam int F_EN      = 0;
  localparam int F_INH     = 1;
  localparam int F_NARROW  = 2;
  localparam int F_SHORT   = 3;
  localparam int F_BYTE    = 4;
  localparam int F_PULSE   = 5;
  localparam int F_W1_LSB  = 8;
  localparam int F_W2_LSB  = 12;
  // fixed top base bits and reserved bits
  localparam logic [CFG_W-1:0] FIXED_SET  = 32'h2000_0000;
  localparam logic [CFG_W-1:0] FIXED_MASK = 32'hE000_0000;
  localparam logic [CFG_W-1:0] RESV_MASK  = 32'h0000_08C0;
  localparam logic [CFG_W-1:0] WR_MASK    = ~(FIXED_MASK | RESV_MASK);
  localparam logic [CFG_W-1:0] CFG_RESET  = FIXED_SET | (32'd1 << F_INH);
endpackage

// File: rtl/csb_cfg_reg.sv
module csb_cfg_reg
  import csb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg
);
  always_ff @(posedge clk) begin
    if (rst)     cfg <= CFG_RESET;
    else if (we) cfg <= (wdata & WR_MASK) | FIXED_SET;
  end
endmodule

// File: rtl/csb_addr_match.sv
module csb_addr_match #(
  parameter int BASE_W = 17
) (
  input  logic              enable,
  input  logic [BASE_W-1:0] addr_hi,
  input  logic [BASE_W-1:0] base,
  output logic              hit
);
  always_comb hit = enable && (addr_hi == base);
endmodule

// File: rtl/csb_beat_seq.sv
module csb_beat_seq #(
  parameter int WAIT_W = 3,
  parameter int BEAT_W = 5,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_burst,
  input  logic              narrow,
  input  logic              short_bl,
  input  logic              pulse_mode,
  input  logic              byte_mode,
  input  logic [WAIT_W-1:0] first_wait,
  input  logic [WAIT_W-1:0] later_wait,
  input  logic              req_write,
  input  logic [LANES-1:0]  req_be,
  output logic              ready,
  output logic              chip_sel,
  output logic              ack,
  output logic              done,
  output logic              bdip,
  output logic [LANES-1:0]  lane_stb
);
  logic              active_q, burst_q, pulse_q;
  logic [BEAT_W-1:0] beat_q, last_q, words, beats, last_d;
  logic [WAIT_W-1:0] wcnt_q, later_q;
  logic [LANES-1:0]  lanes_q;

  always_comb begin
    words  = short_bl ? BEAT_W'(4) : BEAT_W'(8);
    beats  = narrow ? (words << 1) : words;
    last_d = is_burst ? beats - BEAT_W'(1) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      burst_q  <= 1'b0;
      pulse_q  <= 1'b0;
      beat_q   <= '0;
      last_q   <= '0;
      wcnt_q   <= '0;
      later_q  <= '0;
      lanes_q  <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      burst_q  <= is_burst;
      pulse_q  <= pulse_mode;
      beat_q   <= '0;
      last_q   <= last_d;
      wcnt_q   <= first_wait;
      later_q  <= later_wait;
      lanes_q  <= (req_write || byte_mode) ? req_be : '0;
    end else if (active_q) begin
      if (wcnt_q != '0) begin
        wcnt_q <= wcnt_q - WAIT_W'(1);
      end else if (beat_q == last_q) begin
        active_q <= 1'b0;
      end else begin
        beat_q <= beat_q + BEAT_W'(1);
        wcnt_q <= later_q;
      end
    end
  end

  always_comb begin
    ready    = !active_q;
    chip_sel = active_q;
    ack      = active_q && (wcnt_q == '0);
    done     = ack && (beat_q == last_q);
    bdip     = active_q && burst_q && (!pulse_q || beat_q != '0);
    lane_stb = active_q ? lanes_q : '0;
  end
endmodule

// File: rtl/csel_burst_seq.sv
module csel_burst_seq
  import csb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  parameter int BEAT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              bus16,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic [LANES-1:0]  req_be,
  output logic              req_ready,
  output logic              hit,
  output logic              chip_sel,
  output logic              bdip,
  output logic [LANES-1:0]  lane_stb,
  output logic              ack,
  output logic              done
);
  logic [CFG_W-1:0] cfg;
  logic             start, is_burst;

  csb_cfg_reg cfg_i (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg)
  );

  csb_addr_match #(.BASE_W(BASE_W)) match_i (
    .enable (cfg[F_EN]),
    .addr_hi(req_addr[ADDR_W-1 -: BASE_W]),
    .base   (cfg[CFG_W-1 -: BASE_W]),
    .hit    (hit)
  );

  always_comb begin
    start    = req_valid && hit && req_ready;
    is_burst = req_burst && !req_write && !cfg[F_INH];
  end

  csb_beat_seq #(.WAIT_W(WAIT_W), .BEAT_W(BEAT_W), .LANES(LANES)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .is_burst  (is_burst),
    .narrow    (cfg[F_NARROW] || bus16),
    .short_bl  (cfg[F_SHORT]),
    .pulse_mode(cfg[F_PULSE]),
    .byte_mode (cfg[F_BYTE]),
    .first_wait(cfg[F_W1_LSB +: WAIT_W]),
    .later_wait(cfg[F_W2_LSB +: WAIT_W]),
    .req_write (req_write),
    .req_be    (req_be),
    .ready     (req_ready),
    .chip_sel  (chip_sel),
    .ack       (ack),
    .done      (done),
    .bdip      (bdip),
    .lane_stb  (lane_stb)
  );

  assign cfg_rdata = cfg;
endmodule

// File: rtl/csb_checker.sv
module csb_checker (
  input logic       clk,
  input logic       rst,
  input logic       en_bit,
  input logic [2:0] fixed_top,
  input logic [2:0] resv,
  input logic       hit,
  input logic       req_ready,
  input logic       chip_sel,
  input logic       bdip,
  input logic [3:0] lane_stb,
  input logic       ack,
  input logic       done
);
  a_r2_fixed_top: assert property (@(posedge clk) disable iff (rst)
    fixed_top == 3'b001);
  a_r2_resv_zero: assert property (@(posedge clk) disable iff (rst)
    resv == 3'b000);
  a_r3_cs_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(chip_sel) |-> ($past(en_bit) && $past(hit)));
  a_r4_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    chip_sel |-> !req_ready);
  a_r4_end_after_done: assert property (@(posedge clk) disable iff (rst)
    done |=> (!chip_sel && req_ready));
  a_r5_done_with_ack: assert property (@(posedge clk) disable iff (rst)
    done |-> ack);
  a_r5_ack_in_access: assert property (@(posedge clk) disable iff (rst)
    ack |-> chip_sel);
  a_r7_bdip_in_access: assert property (@(posedge clk) disable iff (rst)
    bdip |-> chip_sel);
  a_r9_lanes_idle: assert property (@(posedge clk) disable iff (rst)
    !chip_sel |-> (lane_stb == 4'b0000));
endmodule

bind csel_burst_seq csb_checker chk_i (
  .clk      (clk),
  .rst      (rst),
  .en_bit   (cfg_rdata[0]),
  .fixed_top(cfg_rdata[31:29]),
  .resv     ({cfg_rdata[11], cfg_rdata[7:6]}),
  .hit      (hit),
  .req_ready(req_ready),
  .chip_sel (chip_sel),
  .bdip     (bdip),
  .lane_stb (lane_stb),
  .ack      (ack),
  .done     (done)
);

// File: tb/csel_burst_seq_tb.sv
`timescale 1ns/1ps
module csel_burst_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        bus16 = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_burst = 1'b0;
  logic [3:0]  req_be = '0;
  logic        req_ready, hit, chip_sel, bdip, ack, done;
  logic [3:0]  lane_stb;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam logic [16:0] BASE = 17'h0_5A3C; // top bits 001

  // bench copy of the configuration fields
  logic c_en, c_inh, c_nar, c_short, c_byte, c_pulse;
  logic [2:0] c_w1, c_w2;

  always #2 clk = ~clk;

  csel_burst_seq dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .bus16(bus16), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .req_burst(req_burst),
    .req_be(req_be), .req_ready(req_ready), .hit(hit), .chip_sel(chip_sel),
    .bdip(bdip), .lane_stb(lane_stb), .ack(ack), .done(done)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input logic en, inh, nar, sh, by, pu,
                                         input logic [2:0] w1, w2,
                                         input logic [16:0] base);
    return {base, w2, 1'b0, w1, 2'b00, pu, by, sh, nar, inh, en};
  endfunction

  function automatic logic [31:0] exp_rd(input logic [31:0] w);
    return (w & 32'h1FFF_F73F) | 32'h2000_0000;
  endfunction

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    {c_w2, c_w1} = {w[14:12], w[10:8]};
    {c_pulse, c_byte, c_short, c_nar, c_inh, c_en} = w[5:0];
  endtask

  task automatic set_cfg(input logic en, inh, nar, sh, by, pu,
                         input logic [2:0] w1, w2);
    write_cfg(mk_cfg(en, inh, nar, sh, by, pu, w1, w2, BASE));
  endtask

  task automatic run_acc(input logic [14:0] lo, input logic wr, bst,
                         input logic [3:0] be, input logic b16);
    int nb, k, rem, nacks;
    logic brst;
    logic [8:0] act, exp;
    bit fin;
    @(negedge clk);
    bus16 = b16; req_addr = {BASE, lo}; req_write = wr;
    req_burst = bst; req_be = be; req_valid = 1'b1;
    #1;
    check(hit === 1'b1, "R3 hit on match", {31'd0, hit}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    brst = bst && !wr && !c_inh;
    nb = brst ? ((c_short ? 4 : 8) * ((c_nar || b16) ? 2 : 1)) : 1;
    k = 0; rem = int'(c_w1); nacks = 0; fin = 0;
    for (int c = 0; c < 400 && !fin; c++) begin
      if (c > 0) @(negedge clk);
      #1;
      exp[8] = 1'b1;                              // chip_sel
      exp[7] = 1'b0;                              // req_ready
      exp[6] = (rem == 0);                        // ack
      exp[5] = (rem == 0) && (k == nb - 1);       // done
      exp[4] = brst && (!c_pulse || k != 0);      // bdip
      exp[3:0] = (wr || c_byte) ? be : 4'b0000;   // lanes
      act = {chip_sel, req_ready, ack, done, bdip, lane_stb};
      if (ack) nacks++;
      check(act === exp, "R4 R6 R7 R8 R9 active cycle", {23'd0, act}, {23'd0, exp});
      if (rem == 0) begin
        if (k == nb - 1) fin = 1;
        else begin k++; rem = int'(c_w2); end
      end else rem--;
    end
    check(nacks == nb, "R5 beat count", nacks, nb);
    @(negedge clk); #1;
    check({chip_sel, req_ready} === 2'b01, "R4 release after done",
          {30'd0, chip_sel, req_ready}, 32'd1);
  endtask

  task automatic no_access(input logic [31:0] addr, input string tag);
    @(negedge clk);
    req_addr = addr; req_valid = 1'b1; req_write = 1'b0; req_burst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      check({hit, chip_sel} === 2'b00, tag, {30'd0, hit, chip_sel}, 32'd0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    #1;
    check(chip_sel === 1'b0, tag, {31'd0, chip_sel}, 32'd0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4021));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check(cfg_rdata === 32'h2000_0002, "R1 reset word", cfg_rdata, 32'h2000_0002);
    check({chip_sel, req_ready} === 2'b01, "R1 idle after reset",
          {30'd0, chip_sel, req_ready}, 32'd1);
    // R2 write masking
    write_cfg(32'hFFFF_FFFF); #1;
    check(cfg_rdata === 32'h3FFF_F73F, "R2 all ones", cfg_rdata, 32'h3FFF_F73F);
    write_cfg(32'h0000_0000); #1;
    check(cfg_rdata === 32'h2000_0000, "R2 all zeros", cfg_rdata, 32'h2000_0000);
    write_cfg(32'hA5C3_5AF0); #1;
    check(cfg_rdata === exp_rd(32'hA5C3_5AF0), "R2 pattern", cfg_rdata, exp_rd(32'hA5C3_5AF0));
    // R3 disabled bank and address mismatch
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 3'd1);
    no_access({BASE, 15'h0100}, "R3 disabled bank");
    set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 3'd1);
    no_access({BASE ^ 17'h0_0001, 15'h0100}, "R3 base mismatch");
    // R5 directed beat counts: 4, 8, 16, single for inhibit and write
    set_cfg(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0);
    run_acc(15'h0010, 1'b0, 1'b1, 4'hF, 1'b0);
    set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 3'd1);
    run_acc(15'h0020, 1'b0, 1'b1, 4'hF, 1'b0);
    set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd7, 3'd7);
    run_acc(15'h0030, 1'b0, 1'b1, 4'h3, 1'b1);    // bus16 forces 16 beats
    set_cfg(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3, 3'd3);
    run_acc(15'h0040, 1'b0, 1'b1, 4'hF, 1'b0);    // inhibited: 1 beat
    set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 3'd2);
    run_acc(15'h0050, 1'b1, 1'b1, 4'h9, 1'b0);    // write: 1 beat, R9 lanes
    run_acc(15'h0060, 1'b0, 1'b0, 4'h6, 1'b0);    // R9 read in write-enable mode
    // constrained random mix
    for (int n = 0; n < 40; n++) begin
      logic [31:0] r;
      r = $urandom;
      set_cfg(1'b1, r[0], r[1], r[2], r[3], r[4], r[7:5], r[10:8]);
      r = $urandom;
      run_acc(r[14:0], r[15], r[16] | r[17], r[21:18], r[22] & r[23]);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule